// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. It counts an external oversampling tick at sixteen ticks per bit. A start bit is accepted only when the line is still low at the middle of the bit. Every later bit is sampled at its middle. The block rebuilds a character of five to eight data bits and hands it to a downstream FIFO as a one-cycle valid pulse. The same pulse carries the parity, framing and address status of that character.

Beside the per-character status, the block keeps four sticky flags: parity, framing, break and address-detect. The host clears each one by pulsing its clear input. A line-status interrupt is raised while any of the parity, framing or break flags is set.

In multi-drop mode, the bit slot after the data carries an address marker and is not checked as parity. An optional match mode limits address detection to bytes equal to a programmed value. An inversion control flips the incoming line before any other processing.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, out_valid, all four sticky flags and ls_irq are 0.
- R2: Data bits are taken least significant bit first. len_code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. out_data holds the character right-aligned, with the unused upper bits at 0, and out_valid is high for exactly one cycle per character.
- R3: With par_en=1 and rs485_en=0, one parity bit follows the data. par_even=1 expects an even total count of ones over data and parity, and par_even=0 expects an odd count. A mismatch sets out_pe for that character and sets pe_flag.
- R4: With par_en=1 and par_stick=1, the expected parity bit is fixed: 0 when par_even=1 and 1 when par_even=0.
- R5: A stop bit sampled as 0 sets out_fe and fe_flag. No new character starts until the line has returned to 1.
- R6: bi_flag sets once the line has stayed low for more than (1 + data bits + extra bit + 1) × 16 consecutive ticks. A valid all-zero character never sets it. After a break, reception resumes only once the line has gone high.
- R7: pe_flag, fe_flag, bi_flag and addr_flag hold until their clear input (clr_pe, clr_fe, clr_bi, clr_addr) is pulsed high. ls_irq is the OR of pe_flag, fe_flag and bi_flag.
- R8: With rs485_en=1, the bit after the data is an address marker. It is given on out_addr, and a 1 sets addr_flag. No parity check is made in this mode.
- R9: With rs485_en=1 and aad_en=1, only an address byte whose data equals match_val sets addr_flag. out_match is 1 for exactly such a byte.
- R10: With inv_rx=1, the line is inverted before sampling: an idle-low, inverted waveform is received as the same character.
- R11: A low pulse shorter than half a bit (8 ticks) produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| rx_pin | input | 1 | Serial line input |
| inv_rx | input | 1 | Invert the line before use |
| len_code | input | 2 | Data length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even-parity select |
| par_stick | input | 1 | Fixed parity value select |
| rs485_en | input | 1 | Extra bit is an address marker |
| aad_en | input | 1 | Address detection only on match |
| match_val | input | 8 | Address compare value |
| clr_pe | input | 1 | Clear parity flag |
| clr_fe | input | 1 | Clear framing flag |
| clr_bi | input | 1 | Clear break flag |
| clr_addr | input | 1 | Clear address flag |
| out_valid | output | 1 | Character valid pulse |
| out_data | output | 8 | Received character |
| out_pe | output | 1 | Parity error of this character |
| out_fe | output | 1 | Framing error of this character |
| out_addr | output | 1 | Address marker of this character |
| out_match | output | 1 | Address byte equal to match_val |
| pe_flag | output | 1 | Sticky parity error |
| fe_flag | output | 1 | Sticky framing error |
| bi_flag | output | 1 | Sticky break |
| addr_flag | output | 1 | Sticky address detect |
| ls_irq | output | 1 | Line-status interrupt |

## Verification
The bench covers every length code with random data, random parity modes and deliberately corrupted parity bits. A receiver that shifted the wrong way, or did not right-align short characters, shows up there, and so does one that inverted the even/odd sense. Stick parity is tried at both fixed values. The break test holds the line low past one frame and confirms that an all-zero but well-formed character does not count as a break. A design that timed the break from the stop sample, or restarted while the line was still low, fails that test. Other directed cases cover a short glitch, an inverted idle-low line, the address marker with parity deliberately wrong, and match mode with both equal and unequal bytes.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_pin,
  input  logic       inv_rx,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rs485_en,
  input  logic       aad_en,
  input  logic [7:0] match_val,
  input  logic       clr_pe,
  input  logic       clr_fe,
  input  logic       clr_bi,
  input  logic       clr_addr,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_pe,
  output logic       out_fe,
  output logic       out_addr,
  output logic       out_match,
  output logic       pe_flag,
  output logic       fe_flag,
  output logic       bi_flag,
  output logic       addr_flag,
  output logic       ls_irq
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(11 * OSR + 2);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_XBIT, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    sy;
  logic          rx_s;
  logic [CW-1:0] sc;
  logic [3:0]    bn;
  logic [7:0]    sh;
  logic          xb;
  logic [BW-1:0] lc;

  logic [3:0]    nd;
  logic          xbit_on;
  logic [BW-1:0] lim;
  logic [7:0]    dat;
  logic          exp_par, emit, brk_hit;
  logic          pe_now, addr_now, match_now;

  assign rx_s     = sy[1];
  assign nd       = 4'd5 + {2'b00, len_code};
  assign xbit_on  = par_en | rs485_en;
  assign lim      = BW'((32'(nd) + 32'(xbit_on) + 32'd2) * 32'(OSR));
  assign dat      = sh >> (4'd8 - nd);
  assign exp_par  = par_stick ? ~par_even : (par_even ? ^dat : ~^dat);
  assign pe_now   = par_en & ~rs485_en & (xb != exp_par);
  assign addr_now = rs485_en & xb;
  assign match_now = addr_now & (dat == match_val);
  assign emit     = (st == S_STOP) & tick & (sc == LAST);
  assign brk_hit  = tick & ~rx_s & (lc == lim);
  assign ls_irq   = pe_flag | fe_flag | bi_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rx_pin ^ inv_rx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sc <= '0;
      bn <= '0;
      sh <= '0;
      xb <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!rx_s) begin st <= S_START; sc <= '0; end
        S_START: if (tick) begin
          if (sc == MID) begin
            st <= rx_s ? S_IDLE : S_DATA;
            sc <= '0;
            bn <= '0;
          end else sc <= sc + 1'b1;
        end
        S_DATA: if (tick) begin
          if (sc == LAST) begin
            sc <= '0;
            sh <= {rx_s, sh[7:1]};
            bn <= bn + 1'b1;
            if (bn == nd - 4'd1) st <= xbit_on ? S_XBIT : S_STOP;
          end else sc <= sc + 1'b1;
        end
        S_XBIT: if (tick) begin
          if (sc == LAST) begin sc <= '0; xb <= rx_s; st <= S_STOP; end
          else sc <= sc + 1'b1;
        end
        S_STOP: if (tick) begin
          if (sc == LAST) begin sc <= '0; st <= rx_s ? S_IDLE : S_HOLD; end
          else sc <= sc + 1'b1;
        end
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (brk_hit) st <= S_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lc <= '0;
    else if (rx_s)            lc <= '0;
    else if (tick && lc <= lim) lc <= lc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pe    <= 1'b0;
      out_fe    <= 1'b0;
      out_addr  <= 1'b0;
      out_match <= 1'b0;
      pe_flag   <= 1'b0;
      fe_flag   <= 1'b0;
      bi_flag   <= 1'b0;
      addr_flag <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_data  <= dat;
        out_pe    <= pe_now;
        out_fe    <= ~rx_s;
        out_addr  <= addr_now;
        out_match <= match_now;
      end
      pe_flag   <= (pe_flag & ~clr_pe) | (emit & pe_now);
      fe_flag   <= (fe_flag & ~clr_fe) | (emit & ~rx_s);
      bi_flag   <= (bi_flag & ~clr_bi) | brk_hit;
      addr_flag <= (addr_flag & ~clr_addr) | (emit & addr_now & (~aad_en | match_now));
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_flag && !clr_pe) |=> pe_flag);
  // R7
  addr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_flag && !clr_addr) |=> addr_flag);
  // R5
  fe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> (out_valid && out_fe));
  // R6
  bi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bi_flag) |-> !$past(rx_s));
  // R8
  no_par_in_addr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rs485_en) |-> !out_pe);
endmodule

// File: tb/uart_rx_core_tb.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;
  localparam int BITC = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, line = 1'b1;
  logic inv_rx = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic rs485_en = 1'b0, aad_en = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic [7:0] match_val = 8'h00;
  logic clr_pe = 1'b0, clr_fe = 1'b0, clr_bi = 1'b0, clr_addr = 1'b0;
  logic out_valid, out_pe, out_fe, out_addr, out_match;
  logic [7:0] out_data;
  logic pe_flag, fe_flag, bi_flag, addr_flag, ls_irq;
  logic rx_pin;
  int errors = 0, checks = 0, got = 0;
  logic [7:0] c_data;
  logic c_pe, c_fe, c_addr, c_match;
  logic [1:0] tc = 2'd0;
  bit done = 0;

  assign rx_pin = line ^ inv_rx;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    tc   <= tc + 2'd1;
    tick <= (tc == 2'd3);
    if (out_valid) begin
      got++;
      c_data = out_data; c_pe = out_pe; c_fe = out_fe;
      c_addr = out_addr; c_match = out_match;
    end
  end

  uart_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pin(rx_pin), .inv_rx(inv_rx),
    .len_code(len_code), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rs485_en(rs485_en), .aad_en(aad_en), .match_val(match_val),
    .clr_pe(clr_pe), .clr_fe(clr_fe), .clr_bi(clr_bi), .clr_addr(clr_addr),
    .out_valid(out_valid), .out_data(out_data), .out_pe(out_pe), .out_fe(out_fe),
    .out_addr(out_addr), .out_match(out_match), .pe_flag(pe_flag), .fe_flag(fe_flag),
    .bi_flag(bi_flag), .addr_flag(addr_flag), .ls_irq(ls_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic even, input logic stick);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (stick) return ~even;
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  task automatic hold(input logic v, input int clks);
    line = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nd, input logic hx, input logic xv, input logic sv);
    got = 0;
    hold(1'b0, BITC);
    for (int i = 0; i < nd; i++) hold(d[i], BITC);
    if (hx) hold(xv, BITC);
    hold(sv, BITC);
    hold(1'b1, 2 * BITC);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: clr_pe = 1'b1;
      1: clr_fe = 1'b1;
      2: clr_bi = 1'b1;
      default: clr_addr = 1'b1;
    endcase
    @(negedge clk);
    clr_pe = 1'b0; clr_fe = 1'b0; clr_bi = 1'b0; clr_addr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 flags", {27'd0, pe_flag, fe_flag, bi_flag, addr_flag, ls_irq}, 0);

    // R2 R3 random lengths, parity modes and injected parity errors
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d, m;
      int nd;
      logic flip, pb;
      len_code = 2'($urandom_range(0, 3));
      nd = 5 + int'(len_code);
      m = 8'(((1 << nd) - 1));
      d = 8'($urandom) & m;
      par_en = 1'($urandom);
      par_even = 1'($urandom);
      par_stick = 1'b0;
      flip = par_en && ($urandom_range(0, 3) == 0);
      pb = par_bit(d, par_even, 1'b0) ^ flip;
      send(d, nd, par_en, pb, 1'b1);
      chk("R2 count", got, 1);
      chk("R2 data", {24'd0, c_data}, {24'd0, d});
      chk("R3 out_pe", {31'd0, c_pe}, {31'd0, flip});
      chk("R3 pe_flag", {31'd0, pe_flag}, {31'd0, flip});
      chk("R5 no fe", {31'd0, c_fe}, 0);
      if (pe_flag) pulse(0);
    end

    // R4 stick parity
    len_code = 2'd3; par_en = 1'b1; par_stick = 1'b1;
    par_even = 1'b1;
    send(8'h01, 8, 1'b1, 1'b0, 1'b1);
    chk("R4 stick even ok", {31'd0, c_pe}, 0);
    send(8'h01, 8, 1'b1, 1'b1, 1'b1);
    chk("R4 stick even bad", {31'd0, c_pe}, 1);
    par_even = 1'b0;
    send(8'h03, 8, 1'b1, 1'b1, 1'b1);
    chk("R4 stick odd ok", {31'd0, c_pe}, 0);
    pulse(0);
    chk("R7 pe cleared", {31'd0, pe_flag}, 0);
    par_en = 1'b0; par_stick = 1'b0;

    // R5 framing error
    send(8'h55, 8, 1'b0, 1'b0, 1'b0);
    chk("R5 out_fe", {31'd0, c_fe}, 1);
    chk("R5 fe_flag", {31'd0, fe_flag}, 1);
    chk("R6 no break on short low", {31'd0, bi_flag}, 0);
    chk("R7 ls_irq fe", {31'd0, ls_irq}, 1);
    pulse(1);
    chk("R7 ls_irq cleared", {31'd0, ls_irq}, 0);

    // R6 valid all-zero character is not a break
    send(8'h00, 8, 1'b0, 1'b0, 1'b1);
    chk("R6 zero char data", {24'd0, c_data}, 0);
    chk("R6 zero char no break", {31'd0, bi_flag}, 0);

    // R6 break: low for 12 bits with a 10-bit frame
    got = 0;
    hold(1'b0, 12 * BITC);
    chk("R6 break set", {31'd0, bi_flag}, 1);
    chk("R6 break word fe", {31'd0, c_fe}, 1);
    chk("R6 single word", got, 1);
    hold(1'b1, 2 * BITC);
    send(8'hC3, 8, 1'b0, 1'b0, 1'b1);
    chk("R6 resume", {24'd0, c_data}, 32'hC3);
    pulse(2);
    chk("R7 bi kept fe", {30'd0, bi_flag, ls_irq}, 32'h1);
    pulse(1);
    chk("R7 all clear", {31'd0, ls_irq}, 0);

    // R11 glitch
    got = 0;
    hold(1'b0, 16);
    hold(1'b1, 12 * BITC);
    chk("R11 glitch ignored", got, 0);

    // R10 inversion
    inv_rx = 1'b1;
    hold(1'b1, 2 * BITC);
    send(8'hA6, 8, 1'b0, 1'b0, 1'b1);
    chk("R10 inverted data", {24'd0, c_data}, 32'hA6);
    chk("R10 count", got, 1);
    inv_rx = 1'b0;
    hold(1'b1, 2 * BITC);

    // R8 address marker, parity ignored
    rs485_en = 1'b1; par_en = 1'b1; par_even = 1'b1;
    send(8'hA5, 8, 1'b1, 1'b1, 1'b1);
    chk("R8 out_addr", {31'd0, c_addr}, 1);
    chk("R8 addr_flag", {31'd0, addr_flag}, 1);
    chk("R8 no parity", {31'd0, pe_flag}, 0);
    pulse(3);
    send(8'h5A, 8, 1'b1, 1'b0, 1'b1);
    chk("R8 data byte", {30'd0, c_addr, addr_flag}, 0);

    // R9 match mode
    aad_en = 1'b1; match_val = 8'h3C;
    send(8'h11, 8, 1'b1, 1'b1, 1'b1);
    chk("R9 mismatch", {30'd0, c_match, addr_flag}, 0);
    send(8'h3C, 8, 1'b1, 1'b1, 1'b1);
    chk("R9 match", {30'd0, c_match, addr_flag}, 32'h3);
    chk("R9 data", {24'd0, c_data}, 32'h3C);

    finish_run();
  end
endmodule